// File: doc/BRIEF.md
# Prioritized Data Fault Status Capture

This block keeps a 32-bit record of why the most recent data access aborted. On each cycle it may receive a group of fault flags, one flag per fault kind, together with a valid strobe. It also receives the read/write direction of the failing access, its 4-bit protection domain, and a bit saying whether the bus answered with a decode error or a slave error. When several kinds are flagged in the same cycle, a fixed priority order picks one of them. The chosen kind is mapped to a 5-bit status code. That code is stored split across bit 10 and bits [3:0] of the word, next to the other qualifiers.

Software can read the word at any time on `status_word`. It overwrites the writable fields by pulsing `sw_we`. Each cycle the block makes one update decision, held in an enumerated value with four states:

- `UPD_HOLD`: nothing changes.
- `UPD_SOFT`: the software write is applied.
- `UPD_PRECISE`: every hardware field is captured.
- `UPD_IMPRECISE`: only the low status nibble is captured.

The transitions are as follows:

- A valid cycle with any flag set leads to `UPD_PRECISE`, or to `UPD_IMPRECISE` when the winning kind is imprecise.
- Otherwise, `sw_we` leads to `UPD_SOFT`.
- Otherwise, the decision is `UPD_HOLD`.

No state is carried between cycles apart from the word itself.

Top module: `dfs_capture`

## Requirements
- R1: After reset, and whenever `rst_n` is low at a clock edge, `status_word` is 0x00000000.
- R2: Flag index i of `flt_flags` is one fault kind, and a lower index has higher priority. The indices are:
  - 0 alignment
  - 1 instruction-cache maintenance
  - 2 first-level walk external abort
  - 3 second-level walk external abort
  - 4 first-level walk parity
  - 5 second-level walk parity
  - 6 section translation
  - 7 page translation
  - 8 section access flag
  - 9 page access flag
  - 10 section domain
  - 11 page domain
  - 12 section permission
  - 13 page permission
  - 14 precise non-walk external abort
  - 15 imprecise external abort
  - 16 imprecise parity/ECC
  - 17 debug event

  Only the highest-priority flag that is set is recorded.
- R3: The 5-bit code {bit 10, bits [3:0]} for indices 0 to 17 is, in index order: 00001, 00100, 01100, 01110, 11100, 11110, 00101, 00111, 00011, 00110, 01001, 01011, 01101, 01111, 01000, 10110, 11000, 00010.
- R4: On a capture whose winner is index 2, 3 or 14, bit 12 takes `flt_slave_err` (0 = decode error, 1 = slave error). On any other capture that is not imprecise, bit 12 is written 0.
- R5: On a capture that is not imprecise, bit 11 takes `flt_write` (1 = write) and bits [7:4] take `flt_domain`.
- R6: When the winner is index 15 or 16, only bits [3:0] are loaded (with the code's low nibble), and bits [31:4] keep their values.
- R7: The word updates one cycle after a capture cycle. A capture cycle has `flt_valid` high and at least one flag set. Without a capture or a software write, the word holds.
- R8: When `sw_we` is high and there is no capture, the word is loaded with `sw_wdata` masked to bits 12, 11, 10 and [7:0].
- R9: When a capture and `sw_we` occur in the same cycle, the capture is applied and the write data is discarded.
- R10: Bits [31:13] and [9:8] always read 0, and software writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault flags are valid this cycle |
| flt_flags | input | 18 | One flag per fault kind, index 0 highest priority |
| flt_write | input | 1 | Failing access was a write |
| flt_domain | input | 4 | Protection domain of the failing access |
| flt_slave_err | input | 1 | External abort was a slave error (else decode error) |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| status_word | output | 32 | Recorded fault status word |

## Verification
The bench uses the default parameters: 18 fault kinds, a 4-bit domain and a 32-bit word. With these defaults every status code can be reached, and so can every collision between a high-priority and a low-priority flag. The vector table visits each kind at least once as the winner, including all four external-abort kinds, so both values of the slave qualifier are exercised. Imprecise vectors are ordered so that their low nibble differs from the previous word, which makes a partial update visible. Directed cases cover a held word, a masked software write, and a software write that collides with a capture.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    localparam int FLT_KINDS = 18;
    localparam int KIDX_W    = $clog2(FLT_KINDS);
    localparam int CODE_W    = 5;

    localparam int K_L1_EXT  = 2;
    localparam int K_L2_EXT  = 3;
    localparam int K_NT_EXT  = 14;
    localparam int K_IMP_EXT = 15;
    localparam int K_IMP_PAR = 16;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_SOFT,
        UPD_PRECISE,
        UPD_IMPRECISE
    } upd_e;

    // Status code {hi bit, low nibble} per fault kind index
    function automatic logic [CODE_W-1:0] kind_code(input logic [KIDX_W-1:0] k);
        logic [CODE_W-1:0] c;
        case (k)
            5'd0:    c = 5'b00001;
            5'd1:    c = 5'b00100;
            5'd2:    c = 5'b01100;
            5'd3:    c = 5'b01110;
            5'd4:    c = 5'b11100;
            5'd5:    c = 5'b11110;
            5'd6:    c = 5'b00101;
            5'd7:    c = 5'b00111;
            5'd8:    c = 5'b00011;
            5'd9:    c = 5'b00110;
            5'd10:   c = 5'b01001;
            5'd11:   c = 5'b01011;
            5'd12:   c = 5'b01101;
            5'd13:   c = 5'b01111;
            5'd14:   c = 5'b01000;
            5'd15:   c = 5'b10110;
            5'd16:   c = 5'b11000;
            5'd17:   c = 5'b00010;
            default: c = 5'b00000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dfs_prio_sel.sv
module dfs_prio_sel #(
    parameter int N      = 18,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign hit = seen[N];

    always_comb begin
        idx = '0;
        for (int j = 0; j < N; j++) begin
            if (grant[j]) begin
                idx = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/dfs_code_map.sv
module dfs_code_map
    import dfs_pkg::*;
(
    input  logic [KIDX_W-1:0] idx,
    input  logic              hit,
    output logic [CODE_W-1:0] code,
    output logic              ext_precise,
    output logic              imprecise
);

    always_comb begin
        code        = kind_code(idx);
        ext_precise = hit && ((idx == KIDX_W'(K_L1_EXT)) ||
                              (idx == KIDX_W'(K_L2_EXT)) ||
                              (idx == KIDX_W'(K_NT_EXT)));
        imprecise   = hit && ((idx == KIDX_W'(K_IMP_EXT)) ||
                              (idx == KIDX_W'(K_IMP_PAR)));
    end

endmodule

// File: rtl/dfs_reg.sv
module dfs_reg
    import dfs_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DOM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_e              upd,
    input  logic [CODE_W-1:0] code,
    input  logic              slave_bit,
    input  logic              rw,
    input  logic [DOM_W-1:0]  dom,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] word
);

    localparam int POS_SLV = 12;
    localparam int POS_RW  = 11;
    localparam int POS_SHI = 10;
    localparam int DOM_LSB = 4;
    localparam logic [WORD_W-1:0] WMASK =
        WORD_W'((64'd1 << (POS_SLV + 1)) - 64'd1) & ~WORD_W'(64'h300);

    logic [WORD_W-1:0] precise_word;

    always_comb begin
        precise_word                       = '0;
        precise_word[POS_SLV]              = slave_bit;
        precise_word[POS_RW]               = rw;
        precise_word[POS_SHI]              = code[4];
        precise_word[DOM_LSB +: DOM_W]     = dom;
        precise_word[3:0]                  = code[3:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else begin
            unique case (upd)
                UPD_HOLD:      word      <= word;
                UPD_SOFT:      word      <= sw_wdata & WMASK;
                UPD_PRECISE:   word      <= precise_word;
                UPD_IMPRECISE: word[3:0] <= code[3:0];
                default:       word      <= word;
            endcase
        end
    end

endmodule

// File: rtl/dfs_capture.sv
module dfs_capture
    import dfs_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DOM_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flt_valid,
    input  logic [FLT_KINDS-1:0] flt_flags,
    input  logic                 flt_write,
    input  logic [DOM_W-1:0]     flt_domain,
    input  logic                 flt_slave_err,
    input  logic                 sw_we,
    input  logic [WORD_W-1:0]    sw_wdata,
    output logic [WORD_W-1:0]    status_word
);

    logic [FLT_KINDS-1:0] grant;
    logic [KIDX_W-1:0]    win_idx;
    logic                 any_flag;
    logic [CODE_W-1:0]    win_code;
    logic                 win_ext;
    logic                 win_imp;
    upd_e                 upd;

    dfs_prio_sel #(.N(FLT_KINDS), .IDX_W(KIDX_W)) u_prio (
        .req   (flt_flags),
        .grant (grant),
        .idx   (win_idx),
        .hit   (any_flag)
    );

    dfs_code_map u_map (
        .idx         (win_idx),
        .hit         (any_flag),
        .code        (win_code),
        .ext_precise (win_ext),
        .imprecise   (win_imp)
    );

    // Per-cycle update decision; capture outranks software write
    always_comb begin
        if (flt_valid && any_flag) begin
            upd = win_imp ? UPD_IMPRECISE : UPD_PRECISE;
        end else if (sw_we) begin
            upd = UPD_SOFT;
        end else begin
            upd = UPD_HOLD;
        end
    end

    dfs_reg #(.WORD_W(WORD_W), .DOM_W(DOM_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .code      (win_code),
        .slave_bit (win_ext & flt_slave_err),
        .rw        (flt_write),
        .dom       (flt_domain),
        .sw_wdata  (sw_wdata),
        .word      (status_word)
    );

endmodule

// File: rtl/dfs_capture_chk.sv
module dfs_capture_chk #(
    parameter int WORD_W = 32,
    parameter int DOM_W  = 4,
    parameter int NK     = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_valid,
    input logic [NK-1:0]     flt_flags,
    input logic              flt_write,
    input logic [DOM_W-1:0]  flt_domain,
    input logic              sw_we,
    input logic [WORD_W-1:0] sw_wdata,
    input logic [WORD_W-1:0] status_word
);

    logic cap;
    logic imp_win;
    assign cap     = flt_valid && (|flt_flags);
    assign imp_win = flt_valid && (flt_flags[14:0] == '0) && (flt_flags[15] || flt_flags[16]);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[WORD_W-1:13] == '0) && (status_word[9:8] == 2'b00)); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !sw_we) |=> $stable(status_word)); // R7

    AST_ALIGN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_flags[0]) |=>
        (status_word[12] == 1'b0) && (status_word[10] == 1'b0) && (status_word[3:0] == 4'b0001)); // R2

    AST_PRECISE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !imp_win) |=>
        (status_word[7:4] == $past(flt_domain)) && (status_word[11] == $past(flt_write))); // R5

    AST_IMPRECISE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        imp_win |=> (status_word[WORD_W-1:4] == $past(status_word[WORD_W-1:4]))); // R6

    AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !cap) |=> (status_word == ($past(sw_wdata) & WORD_W'(32'h1CFF)))); // R8

endmodule

bind dfs_capture dfs_capture_chk #(.WORD_W(WORD_W), .DOM_W(DOM_W), .NK(dfs_pkg::FLT_KINDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flt_valid   (flt_valid),
    .flt_flags   (flt_flags),
    .flt_write   (flt_write),
    .flt_domain  (flt_domain),
    .sw_we       (sw_we),
    .sw_wdata    (sw_wdata),
    .status_word (status_word)
);

// File: tb/dfs_capture_test.sv
module dfs_capture_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [17:0] flt_flags = '0;
    logic        flt_write = 1'b0;
    logic [3:0]  flt_domain = '0;
    logic        flt_slave_err = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] status_word;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dfs_capture uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .flt_valid     (flt_valid),
        .flt_flags     (flt_flags),
        .flt_write     (flt_write),
        .flt_domain    (flt_domain),
        .flt_slave_err (flt_slave_err),
        .sw_we         (sw_we),
        .sw_wdata      (sw_wdata),
        .status_word   (status_word)
    );

    // {flags, write, domain, slave, expected word}; applied in order
    localparam int NV = 18;
    localparam logic [55:0] VEC [NV] = '{
        {18'h00001, 1'b1, 4'h5, 1'b1, 32'h00000851},
        {18'h00044, 1'b0, 4'hA, 1'b1, 32'h000010AC},
        {18'h20410, 1'b1, 4'h3, 1'b0, 32'h00000C3C},
        {18'h22000, 1'b0, 4'hF, 1'b1, 32'h000000FF},
        {18'h08000, 1'b1, 4'h2, 1'b1, 32'h000000F6},
        {18'h04000, 1'b1, 4'h7, 1'b1, 32'h00001878},
        {18'h00008, 1'b0, 4'h1, 1'b0, 32'h0000001E},
        {18'h10000, 1'b1, 4'h9, 1'b1, 32'h00000018},
        {18'h00020, 1'b0, 4'h9, 1'b1, 32'h0000049E},
        {18'h20000, 1'b1, 4'h4, 1'b0, 32'h00000842},
        {18'h3FFFE, 1'b0, 4'hC, 1'b1, 32'h000000C4},
        {18'h00180, 1'b0, 4'h0, 1'b0, 32'h00000007},
        {18'h00200, 1'b1, 4'h6, 1'b0, 32'h00000866},
        {18'h00800, 1'b0, 4'h8, 1'b0, 32'h0000008B},
        {18'h01000, 1'b1, 4'h2, 1'b1, 32'h0000082D},
        {18'h00100, 1'b0, 4'h1, 1'b0, 32'h00000013},
        {18'h00400, 1'b0, 4'hE, 1'b0, 32'h000000E9},
        {18'h00040, 1'b1, 4'hD, 1'b0, 32'h000008D5}
    };

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (status_word !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, status_word, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        flt_valid = 1'b0;
        flt_flags = '0;
        sw_we     = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: priority table walk
        for (int i = 0; i < NV; i++) begin
            flt_valid     = 1'b1;
            flt_flags     = VEC[i][55:38];
            flt_write     = VEC[i][37];
            flt_domain    = VEC[i][36:33];
            flt_slave_err = VEC[i][32];
            step();
            check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), VEC[i][31:0]);
        end

        // R7: flags without valid are ignored
        flt_flags = 18'h00001; flt_domain = 4'h3;
        step();
        check("R7 no valid", 32'h000008D5);

        // R7: valid with no flags holds
        flt_valid = 1'b1;
        step();
        check("R7 empty flags", 32'h000008D5);

        // R8 R10: masked software write
        sw_we = 1'b1; sw_wdata = 32'hFFFF_FFFF;
        step();
        check("R8 R10 soft write mask", 32'h00001CFF);

        sw_we = 1'b1; sw_wdata = 32'hABCD_E3A5;
        step();
        check("R8 soft write pattern", 32'h000000A5);

        // R9: capture beats software write
        sw_we = 1'b1; sw_wdata = 32'h0000_1CFF;
        flt_valid = 1'b1; flt_flags = 18'h00004; flt_write = 1'b0;
        flt_domain = 4'h1; flt_slave_err = 1'b0;
        step();
        check("R9 capture wins", 32'h0000001C);

        // R6: imprecise keeps upper bits set by software
        sw_we = 1'b1; sw_wdata = 32'h0000_1CF0;
        step();
        flt_valid = 1'b1; flt_flags = 18'h18000;
        step();
        check("R6 imprecise after soft", 32'h00001CF6);

        // R1: reset mid-run
        rst_n = 1'b0;
        step();
        check("R1 reset mid-run", 32'h0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule